// File: doc/BRIEF.md
# Composite Nibble-Array Multiplier

This block multiplies two unsigned 8-bit operands and returns their full 16-bit product. It does not use one wide multiplier array. Each operand is cut into an upper and a lower 4-bit half. Four small 4 × 4 array multipliers form every pairing of those halves. A weighted adder then shifts each partial result to its proper bit position and sums the three weight classes at full output width.

The block is purely combinational and has no clock or reset. It is meant for a datapath where a product is needed within the same cycle. The block also serves as a building unit for wider products that are composed the same way. The nibble width is a parameter, so the same structure scales in multiples of two halves.

Top module: `nibble_composite_mul`

## Requirements
- R1: Operand A splits into an upper half A[7:4] and a lower half A[3:0], and operand B splits the same way. With B = 0x01, the product equals A, so both halves of A reach the output at their own weight.
- R2: Each 4 × 4 sub-multiplier returns the exact 8-bit unsigned product of its two halves. When both upper halves are zero, the output equals lo(A) × lo(B), with a maximum of 0x00E1.
- R3: The lower×lower sub-product is weighted by 2^0. Output bits [3:0] always equal the low four bits of lo(A) × lo(B).
- R4: Both cross sub-products, hi(A)×lo(B) and lo(A)×hi(B), are weighted by 2^4. For example, 0x10 × 0x01 = 0x0010 and 0x01 × 0x10 = 0x0010.
- R5: The upper×upper sub-product is weighted by 2^8. For example, 0xF0 × 0xF0 = 0xE100, and the output shifted right by 8 is never below hi(A) × hi(B).
- R6: The 16-bit output equals A × B for every one of the 65,536 operand pairs. No carry is lost, and the largest result is 0xFE01.
- R7: The output is combinational. A change on either operand shows on the product with no clock edge in between.
- R8: If either operand is zero, the product is 0x0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_a | input | 8 | Unsigned multiplicand |
| op_b | input | 8 | Unsigned multiplier |
| product | output | 16 | Unsigned full-width product op_a × op_b |

## Verification
Directed single-half patterns come first, such as a lone 1 in one nibble of each operand and all-ones in the upper halves. Each of these lights exactly one sub-multiplier, so a misplaced weight shows up as a product at the wrong offset. Patterns with both upper halves zero isolate the lower×lower array. Zero operands separate a stuck partial product from a true zero. The exhaustive sweep over every operand pair then catches carries dropped between the cross sum and the upper byte, which only certain operand combinations produce. A mid-cycle operand change confirms that the product does not wait for a clock.

// File: rtl/nibmul_pkg.sv
package nibmul_pkg;

  localparam int unsigned DEF_NIB_W = 4;

  // one-bit full-adder sum
  function automatic logic fa_sum(input logic x, input logic y, input logic cin);
    return x ^ y ^ cin;
  endfunction

  // one-bit full-adder carry
  function automatic logic fa_carry(input logic x, input logic y, input logic cin);
    return (x & y) | (x & cin) | (y & cin);
  endfunction

  // index of a sub-product: bit0 picks the A half, bit1 picks the B half
  function automatic int unsigned sub_shift(input int unsigned idx, input int unsigned nib_w);
    return (((idx >> 0) & 1) + ((idx >> 1) & 1)) * nib_w;
  endfunction

endpackage

// File: rtl/nib_array_mul.sv
module nib_array_mul
  import nibmul_pkg::*;
#(
  parameter int unsigned N = DEF_NIB_W
) (
  input  logic [N-1:0]   a,
  input  logic [N-1:0]   b,
  output logic [2*N-1:0] p
);

  localparam int unsigned PW = 2 * N;

  logic [N-1:0] pp    [N];
  logic [N-1:0] carry_row [N];
  logic [N-1:0] rsum  [N];
  logic [N:0]   rc    [N];

  genvar i, j;
  generate
    for (i = 0; i < N; i++) begin : g_pp
      assign pp[i] = a & {N{b[i]}};
    end

    assign rsum[0]      = pp[0];
    assign rc[0]        = '0;
    assign p[0]         = pp[0][0];
    assign carry_row[0] = {1'b0, pp[0][N-1:1]};

    for (i = 1; i < N; i++) begin : g_row
      assign rc[i][0] = 1'b0;
      for (j = 0; j < N; j++) begin : g_fa
        assign rsum[i][j]  = fa_sum  (carry_row[i-1][j], pp[i][j], rc[i][j]);
        assign rc[i][j+1]  = fa_carry(carry_row[i-1][j], pp[i][j], rc[i][j]);
      end
      assign p[i]         = rsum[i][0];
      assign carry_row[i] = {rc[i][N], rsum[i][N-1:1]};
    end

    assign p[PW-1:N] = carry_row[N-1];
  endgenerate

  logic [PW-1:0] model_p;
  assign model_p = PW'(a) * PW'(b);

  always_comb begin
    if (!$isunknown({a, b})) begin
      // R2: array result matches an arithmetic multiply of the halves
      a_r2_sub_exact: assert (p == model_p)
        else $error("sub-product %0h x %0h gave %0h", a, b, p);
    end
  end

endmodule

// File: rtl/nib_weight_sum.sv
module nib_weight_sum
  import nibmul_pkg::*;
#(
  parameter int unsigned N = DEF_NIB_W
) (
  input  logic [2*N-1:0] sp_ll,
  input  logic [2*N-1:0] sp_hl,
  input  logic [2*N-1:0] sp_lh,
  input  logic [2*N-1:0] sp_hh,
  output logic [4*N-1:0] total
);

  localparam int unsigned SPW = 2 * N;
  localparam int unsigned OW  = 4 * N;

  logic [SPW:0]  cross_sum;
  logic [OW-1:0] w_ll, w_cross, w_hh;

  assign cross_sum = {1'b0, sp_hl} + {1'b0, sp_lh};
  assign w_ll      = OW'(sp_ll);
  assign w_cross   = OW'(cross_sum) << N;
  assign w_hh      = OW'(sp_hh) << (2 * N);
  assign total     = w_ll + w_cross + w_hh;

  always_comb begin
    if (!$isunknown({sp_ll, sp_hl, sp_lh, sp_hh})) begin
      // R3: lowest nibble of the sum comes only from the low x low term
      a_r3_low_nibble: assert (total[N-1:0] == sp_ll[N-1:0])
        else $error("low nibble %0h vs %0h", total[N-1:0], sp_ll[N-1:0]);
      // R6: the sum never wraps below its largest term
      a_r6_no_overflow: assert (total >= w_hh && total >= w_cross)
        else $error("weighted sum wrapped: %0h", total);
    end
  end

endmodule

// File: rtl/nibble_composite_mul.sv
module nibble_composite_mul
  import nibmul_pkg::*;
#(
  parameter int unsigned NIB_W = DEF_NIB_W
) (
  input  logic [2*NIB_W-1:0] op_a,
  input  logic [2*NIB_W-1:0] op_b,
  output logic [4*NIB_W-1:0] product
);

  localparam int unsigned OPW = 2 * NIB_W;
  localparam int unsigned OW  = 4 * NIB_W;
  localparam int unsigned NSUB = 4;

  // R1: operand halves
  logic [NIB_W-1:0] a_half [2];
  logic [NIB_W-1:0] b_half [2];
  assign a_half[0] = op_a[NIB_W-1:0];
  assign a_half[1] = op_a[OPW-1:NIB_W];
  assign b_half[0] = op_b[NIB_W-1:0];
  assign b_half[1] = op_b[OPW-1:NIB_W];

  // sub_p[k]: k[0] selects A half, k[1] selects B half
  logic [OPW-1:0] sub_p [NSUB];

  genvar k;
  generate
    for (k = 0; k < NSUB; k++) begin : g_sub
      nib_array_mul #(.N(NIB_W)) u_mul (
        .a (a_half[k % 2]),
        .b (b_half[k / 2]),
        .p (sub_p[k])
      );
    end
  endgenerate

  nib_weight_sum #(.N(NIB_W)) u_sum (
    .sp_ll (sub_p[0]),
    .sp_hl (sub_p[1]),
    .sp_lh (sub_p[2]),
    .sp_hh (sub_p[3]),
    .total (product)
  );

  logic [OW-1:0] model_prod;
  assign model_prod = OW'(op_a) * OW'(op_b);

  always_comb begin
    if (!$isunknown({op_a, op_b})) begin
      // R6: composed result equals the full multiply
      a_r6_exact: assert (product == model_prod)
        else $error("product %0h x %0h gave %0h", op_a, op_b, product);
      // R8: any zero operand yields zero
      a_r8_zero: assert (!(op_a == '0 || op_b == '0) || product == '0)
        else $error("zero operand gave %0h", product);
      // R5: the upper byte carries at least the high x high term
      a_r5_hh_weight: assert ((product >> OPW) >= OW'(sub_p[3]))
        else $error("high term misplaced: %0h", product);
    end
  end

endmodule

// File: tb/tb_nibble_composite_mul.sv
module tb_nibble_composite_mul;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  op_a = '0;
  logic [7:0]  op_b = '0;
  logic [15:0] product;

  int checks = 0;
  int errors = 0;
  int exp_q[$];

  always #4 clk = ~clk;

  nibble_composite_mul dut (
    .op_a    (op_a),
    .op_b    (op_b),
    .product (product)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // drive after a rising edge, reference pushed to the queue
  task automatic drive(input int a, input int b);
    @(posedge clk);
    #1;
    op_a = 8'(a);
    op_b = 8'(b);
    exp_q.push_back(a * b);
    @(negedge clk);
  endtask

  task automatic run_pair(input int a, input int b, input string req);
    int e;
    drive(a, b);
    e = exp_q.pop_front();
    check(int'(product) == e, req, int'(product), e);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    int e;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R8: reset state with zero operands
    check(product == 16'h0000, "R8 reset", int'(product), 0);
    rst = 1'b0;

    // R1: both halves of A reach the output with B = 1
    run_pair(8'hA5, 8'h01, "R1");
    run_pair(8'h5A, 8'h01, "R1");
    // R2: only the low x low array active
    run_pair(8'h0F, 8'h0F, "R2");
    run_pair(8'h07, 8'h09, "R2");
    // R4: cross terms at weight 16
    run_pair(8'h10, 8'h01, "R4");
    run_pair(8'h01, 8'h10, "R4");
    run_pair(8'hF0, 8'h0F, "R4");
    // R5: high x high at weight 256
    run_pair(8'hF0, 8'hF0, "R5");
    check(int'(product >> 8) >= 15 * 15, "R5 bound", int'(product >> 8), 225);
    // R8: zero operands
    run_pair(8'h00, 8'hFF, "R8");
    run_pair(8'hFF, 8'h00, "R8");
    // R6: largest product
    run_pair(8'hFF, 8'hFF, "R6");

    // R7: mid-cycle change without a clock edge
    @(negedge clk);
    #1;
    op_a = 8'h23;
    op_b = 8'h45;
    #1;
    check(int'(product) == 8'h23 * 8'h45, "R7", int'(product), 8'h23 * 8'h45);

    // R6 and R3: exhaustive sweep
    for (int i = 0; i < 65536; i++) begin
      int a, b;
      a = i / 256;
      b = i % 256;
      drive(a, b);
      e = exp_q.pop_front();
      check(int'(product) == e, "R6", int'(product), e);
      check(int'(product[3:0]) == (((a % 16) * (b % 16)) % 16), "R3",
            int'(product[3:0]), ((a % 16) * (b % 16)) % 16);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule